// File: doc/BRIEF.md
# Eight-Line GPIO Port with Per-Line Interrupt Sensing

This block is an eight-line general-purpose I/O port on a simple single-cycle register bus. Each line can be an output, driven from a latch, or an input, taken through a two-flop synchronizer. A write is accepted on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Every line has its own interrupt logic. Per line, software chooses between level and edge sensing and picks the active polarity. Software also gates the line with an enable bit and can switch on a debounce filter. Edge events are held in a sticky latch, and a write-one-to-clear acknowledge register releases them. Level sources follow the filtered input directly.

The per-line status can be read back. By default the status bits are ORed into one port interrupt. A build option brings out one interrupt wire per line instead.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-low reset, all writable registers read 0, `pin_oe` and `pin_out` are 0, and both interrupt outputs are low.
- R2: A direction bit of 1 makes the line an output, with `pin_oe` equal to the direction register and `pin_out` equal to the output latch. Reading the data register returns the latch bit for output lines and the two-flop-synchronized pin level for input lines.
- R3: A line whose sense-mode bit is 0 (level sensing) shows status 1 exactly while it is enabled and its qualified input equals its polarity bit (1 = high, 0 = low).
- R4: A line whose sense-mode bit is 1 (edge sensing) sets a sticky status on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. The status stays set until acknowledged, or until the line is disabled or switched to level mode.
- R5: Writing the acknowledge register clears the edge latch of every line whose written bit is 1. Bits written as 0 leave their lines untouched, and level-sensed lines ignore the write entirely.
- R6: A line with its enable bit at 0 has status 0 and latches nothing. Input transitions that occur while it is disabled never appear after it is enabled.
- R7: Rewriting the polarity bit of an enabled edge line produces no event by itself. The next input edge of the new polarity sets the status.
- R8: With a line's filter bit set, its qualified input changes only after the synchronized level has differed from it on 4 consecutive sample ticks, one tick every `DEB_DIV` clocks. Shorter pulses are dropped. With the bit clear, the synchronized level is used directly.
- R9: With `PER_LINE_IRQ` = 0, `irq_port` is the OR of all status bits and `irq_line` is 0. With 1, `irq_line[i]` is status bit i and `irq_port` is 0.
- R10: The register map is fixed:
  - data 0x00, direction 0x10, sense-mode 0x90, polarity 0x94, enable 0x9C and filter 0xA8;
  - status is read-only at 0xA0;
  - acknowledge is at 0x98 and reads 0;
  - every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output latch driven toward the pads |
| pin_oe | output | 8 | Per-line output enable (direction register) |
| irq_port | output | 1 | OR of all line status bits (combined variant) |
| irq_line | output | 8 | Per-line status outputs (split variant) |

## Verification
The table-driven part uses a separate line for each of the eight combinations of sense mode, polarity, enable and input transition. This separates the level-high and level-low matches and rising from falling edges, and it shows that an edge of the wrong direction or a disabled line stays silent.

Directed patterns then cover the remaining cases:
- a rising edge followed by acknowledge and a polarity flip on an enabled line, which shows that the flip itself produces no event;
- acknowledge writes with the line's bit at 0, and acknowledge writes to a level line;
- an input edge made while the line is disabled;
- a short pulse against a held level on a filtered line, which shows that the filter drops brief pulses but passes a steady change.

// File: rtl/gpio_irq_pkg.sv
// Register map and shared sizes for the GPIO interrupt port.
// Assumes an 8-bit address space with byte-wide registers.
package gpio_irq_pkg;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] A_DATA   = 8'h00;
    localparam logic [ADDR_W-1:0] A_DIR    = 8'h10;
    localparam logic [ADDR_W-1:0] A_MODE   = 8'h90;
    localparam logic [ADDR_W-1:0] A_POL    = 8'h94;
    localparam logic [ADDR_W-1:0] A_ACK    = 8'h98;
    localparam logic [ADDR_W-1:0] A_EN     = 8'h9C;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'hA0;
    localparam logic [ADDR_W-1:0] A_FILT   = 8'hA8;
endpackage

// File: rtl/gpio_in_filter.sv
// One input line: two-flop synchronizer followed by an optional
// stability filter. Assumes `tick` is a one-cycle pulse from a shared
// divider. With filtering off the filtered level tracks the synchronizer
// so that switching the filter on never causes a jump.
module gpio_in_filter #(
    parameter int STABLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    input  logic filt_en,
    output logic sync_o,
    output logic qual_o
);
    localparam int CW = $clog2(STABLE_TICKS + 1);

    logic meta_q, sync_q, filt_q;
    logic [CW-1:0] run_q;

    // Two-stage synchronizer for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
        end
    end

    // Count consecutive ticks on which the synchronized level disagrees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
        end else if (!filt_en) begin
            filt_q <= sync_q;
            run_q  <= '0;
        end else if (tick) begin
            if (sync_q == filt_q) begin
                run_q <= '0;
            end else if (run_q == CW'(STABLE_TICKS - 1)) begin
                filt_q <= sync_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign sync_o = sync_q;
    assign qual_o = filt_en ? filt_q : sync_q;
endmodule

// File: rtl/gpio_irq_cell.sv
// Interrupt sensing for one line. Level mode reports the live match of
// the qualified input against the polarity bit. Edge mode keeps a sticky
// latch. Edges are found from the input history, not from the polarity
// bit, so a polarity rewrite creates no event. A disabled line latches
// nothing.
module gpio_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic qual,
    input  logic en,
    input  logic edge_mode,
    input  logic pol_high,
    input  logic ack,
    output logic status
);
    logic prev_q, hold_q, hit;

    // Remember last cycle's qualified level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= qual;
    end

    assign hit = pol_high ? (qual & ~prev_q) : (~qual & prev_q);

    // Sticky edge latch; a new edge wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                hold_q <= 1'b0;
        else if (!en || !edge_mode) hold_q <= 1'b0;
        else if (hit)              hold_q <= 1'b1;
        else if (ack)              hold_q <= 1'b0;
    end

    assign status = en & (edge_mode ? hold_q : (qual == pol_high));
endmodule

// File: rtl/gpio_irq_port.sv
// Top of the GPIO port: register file, tick divider, per-line filter and
// interrupt cells, and the interrupt output variant. Assumes a single
// master on a one-cycle write bus with combinational read data.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N            = 8,
    parameter int DEB_DIV      = 4,
    parameter int STABLE_TICKS = 4,
    parameter bit PER_LINE_IRQ = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pin_in,
    output logic [N-1:0]      pin_out,
    output logic [N-1:0]      pin_oe,
    output logic              irq_port,
    output logic [N-1:0]      irq_line
);
    localparam int DW = (DEB_DIV > 1) ? $clog2(DEB_DIV) : 1;

    logic [N-1:0] out_q, dir_q, mode_q, pol_q, en_q, filt_q;
    logic [N-1:0] sync_v, qual_v, status, ack_v;
    logic [DW-1:0] div_q;
    logic tick;

    // Register writes on the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
            filt_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DATA:  out_q  <= bus_wdata;
                A_DIR:   dir_q  <= bus_wdata;
                A_MODE:  mode_q <= bus_wdata;
                A_POL:   pol_q  <= bus_wdata;
                A_EN:    en_q   <= bus_wdata;
                A_FILT:  filt_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Acknowledge bits are a one-cycle pulse, never stored.
    assign ack_v = (bus_wr && bus_addr == A_ACK) ? bus_wdata : '0;

    // Read multiplexer.
    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = (out_q & dir_q) | (sync_v & ~dir_q);
            A_DIR:   bus_rdata = dir_q;
            A_MODE:  bus_rdata = mode_q;
            A_POL:   bus_rdata = pol_q;
            A_EN:    bus_rdata = en_q;
            A_FILT:  bus_rdata = filt_q;
            A_STAT:  bus_rdata = status;
            default: bus_rdata = '0;
        endcase
    end

    // Shared sample-tick divider for the filters.
    always_ff @(posedge clk) begin
        if (!rst_n)                          div_q <= '0;
        else if (div_q == DW'(DEB_DIV - 1))  div_q <= '0;
        else                                 div_q <= div_q + 1'b1;
    end
    assign tick = (div_q == DW'(DEB_DIV - 1));

    generate
        for (genvar i = 0; i < N; i++) begin : g_line
            gpio_in_filter #(.STABLE_TICKS(STABLE_TICKS)) u_filt (
                .clk(clk), .rst_n(rst_n), .tick(tick), .pin(pin_in[i]),
                .filt_en(filt_q[i]), .sync_o(sync_v[i]), .qual_o(qual_v[i])
            );
            gpio_irq_cell u_cell (
                .clk(clk), .rst_n(rst_n), .qual(qual_v[i]), .en(en_q[i]),
                .edge_mode(mode_q[i]), .pol_high(pol_q[i]), .ack(ack_v[i]),
                .status(status[i])
            );
        end
        if (PER_LINE_IRQ) begin : g_split
            assign irq_line = status;
            assign irq_port = 1'b0;
        end else begin : g_merged
            assign irq_line = '0;
            assign irq_port = |status;
        end
    endgenerate

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Property checker for gpio_irq_port, attached by bind.
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int N            = 8,
    parameter bit PER_LINE_IRQ = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [N-1:0]      bus_rdata,
    input logic [N-1:0]      status,
    input logic [N-1:0]      en_q,
    input logic [N-1:0]      mode_q,
    input logic              irq_port,
    input logic [N-1:0]      irq_line
);
    logic ack_wr, cfg_wr;
    assign ack_wr = bus_wr && (bus_addr == A_ACK);
    assign cfg_wr = bus_wr && (bus_addr == A_EN || bus_addr == A_MODE);

    // R6
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~en_q) == '0);

    // R4
    edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_wr && !cfg_wr) |=>
        ((status & $past(status & en_q & mode_q)) == $past(status & en_q & mode_q)));

    // R10
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_ACK) |-> (bus_rdata == '0));

    generate
        if (PER_LINE_IRQ) begin : g_split
            // R9
            irq_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_line == status) && !irq_port);
        end else begin : g_merged
            // R9
            irq_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_port == (status != '0)) && (irq_line == '0));
        end
    endgenerate
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N(N), .PER_LINE_IRQ(PER_LINE_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .status(status), .en_q(en_q), .mode_q(mode_q),
    .irq_port(irq_port), .irq_line(irq_line)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe, irq_line;
    logic       irq_port;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gpio_irq_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_port(irq_port),
        .irq_line(irq_line)
    );

    always #5 clk = ~clk;

    // {line[2:0], mode, pol, en, start, finish, expect}
    localparam logic [8:0] VEC [0:7] = '{
        {3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
        {3'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
        {3'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {3'd4, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        {3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        {3'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {3'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        foreach (VEC[k]) begin end
        rd(8'h10, r); check("R1 dir", r, 8'h00);
        rd(8'h9C, r); check("R1 enable", r, 8'h00);
        rd(8'h90, r); check("R1 mode", r, 8'h00);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        check("R1 irq", {7'd0, irq_port}, 8'h00);

        // R3 R4 R6 R9 table walk
        for (int k = 0; k < 8; k++) begin
            logic [2:0] ln;
            logic [7:0] m;
            ln = VEC[k][8:6];
            m  = 8'h01 << ln;
            wr(8'h9C, 8'h00);
            pin_in = VEC[k][2] ? m : 8'h00;
            idle(5);
            wr(8'h90, VEC[k][5] ? m : 8'h00);
            wr(8'h94, VEC[k][4] ? m : 8'h00);
            wr(8'h98, 8'hFF);
            wr(8'h9C, VEC[k][3] ? m : 8'h00);
            idle(3);
            pin_in = VEC[k][1] ? m : 8'h00;
            idle(5);
            rd(8'hA0, r);
            check($sformatf("R3/R4/R6 vector %0d status", k), r, VEC[k][0] ? m : 8'h00);
            check($sformatf("R9 vector %0d irq_port", k), {7'd0, irq_port}, {7'd0, VEC[k][0]});
        end
        wr(8'h9C, 8'h00);
        pin_in = 8'h00;
        idle(5);

        // R2 direction and data
        wr(8'h10, 8'hF0);
        wr(8'h00, 8'hA5);
        pin_in = 8'h3C;
        idle(4);
        rd(8'h00, r); check("R2 data read mix", r, 8'hAC);
        check("R2 pin_oe", pin_oe, 8'hF0);
        check("R2 pin_out", pin_out, 8'hA5);
        wr(8'h10, 8'h00);
        pin_in = 8'h00;
        idle(5);

        // R7 polarity flip on enabled edge line 3, then R5 acknowledge
        wr(8'h90, 8'h08); wr(8'h94, 8'h08); wr(8'h9C, 8'h08);
        pin_in = 8'h08; idle(5);
        rd(8'hA0, r); check("R4 rising latched", r, 8'h08);
        pin_in = 8'h00; idle(5);
        rd(8'hA0, r); check("R4 sticky after input returns", r, 8'h08);
        wr(8'h98, 8'h08); idle(2);
        rd(8'hA0, r); check("R5 ack clears", r, 8'h00);
        pin_in = 8'h08; idle(5);
        wr(8'h98, 8'h08); idle(2);
        wr(8'h94, 8'h00); idle(5);
        rd(8'hA0, r); check("R7 flip makes no event", r, 8'h00);
        pin_in = 8'h00; idle(5);
        rd(8'hA0, r); check("R7 next falling edge", r, 8'h08);
        wr(8'h98, 8'hF7); idle(2);
        rd(8'hA0, r); check("R5 zero bits ignored", r, 8'h08);
        wr(8'h98, 8'h08); idle(2);
        rd(8'hA0, r); check("R5 ack clears falling", r, 8'h00);

        // R6 edge while disabled does not appear later (line 4)
        wr(8'h9C, 8'h00);
        wr(8'h90, 8'h10); wr(8'h94, 8'h10);
        pin_in = 8'h10; idle(5);
        wr(8'h9C, 8'h10); idle(3);
        rd(8'hA0, r); check("R6 no edge from disabled period", r, 8'h00);
        pin_in = 8'h00; idle(4); pin_in = 8'h10; idle(5);
        rd(8'hA0, r); check("R6 edge after enable", r, 8'h10);

        // R5 level line ignores acknowledge (line 5)
        wr(8'h9C, 8'h00);
        wr(8'h90, 8'h00); wr(8'h94, 8'h20);
        pin_in = 8'h20; idle(4);
        wr(8'h9C, 8'h20); idle(2);
        wr(8'h98, 8'h20); idle(2);
        rd(8'hA0, r); check("R5 level ignores ack", r, 8'h20);
        rd(8'h98, r); check("R10 ack reads zero", r, 8'h00);
        rd(8'h44, r); check("R10 unmapped reads zero", r, 8'h00);
        rd(8'h94, r); check("R10 polarity readback", r, 8'h20);

        // R8 filter on line 6 (level high)
        wr(8'h9C, 8'h00);
        pin_in = 8'h00; idle(4);
        wr(8'hA8, 8'h40); wr(8'h94, 8'h40); wr(8'h9C, 8'h40);
        idle(4);
        pin_in = 8'h40; idle(3); pin_in = 8'h00;
        idle(30);
        rd(8'hA0, r); check("R8 short pulse dropped", r, 8'h00);
        pin_in = 8'h40; idle(8);
        rd(8'hA0, r); check("R8 not yet stable", r, 8'h00);
        idle(32);
        rd(8'hA0, r); check("R8 held level passes", r, 8'h40);
        wr(8'hA8, 8'h00); pin_in = 8'h00; idle(4);
        rd(8'hA0, r); check("R8 filter off follows sync", r, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule